// File: doc/BRIEF.md
# Shadow Register Context Save

This block gives a processor core a one-level store for a fast context save and restore, held in hidden registers. One strobe pair covers the four lowest working registers and five arithmetic flags of the status word. A second strobe pair, independent of the first, covers the hardware-loop start address, end address and iteration count. The core raises the loop push strobe when a loop begins and the loop pop strobe when it ends.

Each shadow sits behind exactly one host register. Nothing outside the block can read or write a shadow except through a push and a later pop. On a pop the block loads its registered restore outputs and raises a one-cycle restore-valid flag for that group. The core copies the restore outputs into its host registers in that cycle. Status bits that are not shadowed pass through from the status input sampled in the pop cycle, so a pop leaves them unchanged.

Top module: `ctx_shadow_store`

## Requirements
- R1: During and right after synchronous reset, every restore output is zero and both restore-valid outputs are low.
- R2: After a context push, a context pop loads `wreg_out` with the four working registers captured at the push. Lane k sits at bits [16k+15:16k]. `ctx_restore_vld` is high in the cycle after the pop and only then.
- R3: In `stat_out` only bit 0 (carry), bit 1 (zero), bit 2 (overflow), bit 3 (negative) and bit 8 (digit carry) come from the shadow. Every other bit equals `stat_in` as sampled on the pop edge.
- R4: A loop push captures `lstart_in`, `lend_in` and `lcount_in`. A later loop pop presents them on `lstart_out`, `lend_out` and `lcount_out`, with `loop_restore_vld` high for one cycle.
- R5: The shadows are one level deep. A second push before a pop replaces the earlier values.
- R6: The two groups are independent. Strobes of one group never alter the outputs or shadows of the other, and all four strobes may be high in the same cycle.
- R7: A pop with no earlier push returns zero in every shadowed bit.
- R8: A push and a pop of the same group in one cycle restore the values held before that cycle, and the new values are kept for the next pop.
- R9: Restore outputs change only on the edge that follows a pop of their group.
- R10: Host inputs that change without a push have no effect on what a later pop returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_push | input | 1 | Save working registers and status flags |
| ctx_pop | input | 1 | Restore working registers and status flags |
| wreg_in | input | 64 | Host working registers 0..3, register k at bits [16k+15:16k] |
| stat_in | input | 16 | Host status word |
| loop_push | input | 1 | Hardware loop start: save loop registers |
| loop_pop | input | 1 | Hardware loop end: restore loop registers |
| lstart_in | input | 24 | Host loop start address |
| lend_in | input | 24 | Host loop end address |
| lcount_in | input | 14 | Host loop count |
| wreg_out | output | 64 | Restored working registers |
| stat_out | output | 16 | Restored status word (unshadowed bits pass through) |
| ctx_restore_vld | output | 1 | One-cycle pulse after a context pop |
| lstart_out | output | 24 | Restored loop start address |
| lend_out | output | 24 | Restored loop end address |
| lcount_out | output | 14 | Restored loop count |
| loop_restore_vld | output | 1 | One-cycle pulse after a loop pop |

## Verification
A push and a pop of the same group can land on one edge. A context event and a loop event can also fire together. The bench forces both: directed steps raise push and pop together and check that the older values come back while the newer ones are kept. A sweep then cycles through all sixteen combinations of the four strobes with fresh pseudo-random data on every edge. An arithmetic model in the bench tracks the shadows and outputs of each group on its own, so a wrong same-edge ordering or any leak between groups shows up as a mismatch on the ports.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;
  localparam int STAT_W      = 16;
  localparam int FLAG_C_BIT  = 0;
  localparam int FLAG_Z_BIT  = 1;
  localparam int FLAG_OV_BIT = 2;
  localparam int FLAG_N_BIT  = 3;
  localparam int FLAG_DC_BIT = 8;
  localparam logic [STAT_W-1:0] STAT_SAVE_MASK =
    STAT_W'(( 1 << FLAG_C_BIT) | (1 << FLAG_Z_BIT) | (1 << FLAG_OV_BIT) |
            ( 1 << FLAG_N_BIT) | (1 << FLAG_DC_BIT));
endpackage

// File: rtl/shadow_slot.sv
module shadow_slot #(
  parameter int         W         = 16,
  parameter logic [W-1:0] SAVE_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] host_in,
  output logic [W-1:0] restore_out
);
  logic [W-1:0] shadow_q;

  // Hidden holding register: only masked bits are stored.
  always_ff @(posedge clk) begin
    if (rst)       shadow_q <= '0;
    else if (push) shadow_q <= host_in & SAVE_MASK;
  end

  // Restore register: pop reads the value held before this edge.
  always_ff @(posedge clk) begin
    if (rst)      restore_out <= '0;
    else if (pop) restore_out <= shadow_q | (host_in & ~SAVE_MASK);
  end

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !pop |=> $stable(restore_out)); // R9
  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) ##1 (pop && !push) |=>
      ((restore_out & SAVE_MASK) == ($past(host_in, 2) & SAVE_MASK))); // R2
endmodule

// File: rtl/restore_strobe.sv
module restore_strobe (
  input  logic clk,
  input  logic rst,
  input  logic pop,
  output logic vld
);
  always_ff @(posedge clk) begin
    if (rst) vld <= 1'b0;
    else     vld <= pop;
  end
endmodule

// File: rtl/ctx_shadow_store.sv
module ctx_shadow_store
  import ctx_shadow_pkg::*;
#(
  parameter int NUM_WREG    = 4,
  parameter int DATA_W      = 16,
  parameter int LOOP_ADDR_W = 24,
  parameter int LOOP_CNT_W  = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ctx_push,
  input  logic                       ctx_pop,
  input  logic [NUM_WREG*DATA_W-1:0] wreg_in,
  input  logic [STAT_W-1:0]          stat_in,
  input  logic                       loop_push,
  input  logic                       loop_pop,
  input  logic [LOOP_ADDR_W-1:0]     lstart_in,
  input  logic [LOOP_ADDR_W-1:0]     lend_in,
  input  logic [LOOP_CNT_W-1:0]      lcount_in,
  output logic [NUM_WREG*DATA_W-1:0] wreg_out,
  output logic [STAT_W-1:0]          stat_out,
  output logic                       ctx_restore_vld,
  output logic [LOOP_ADDR_W-1:0]     lstart_out,
  output logic [LOOP_ADDR_W-1:0]     lend_out,
  output logic [LOOP_CNT_W-1:0]      lcount_out,
  output logic                       loop_restore_vld
);
  localparam int WBUS_W = NUM_WREG * DATA_W;

  // Context group: working registers, one slot per register.
  for (genvar g = 0; g < NUM_WREG; g++) begin : g_wreg
    shadow_slot #(.W(DATA_W), .SAVE_MASK('1)) u_slot (
      .clk(clk), .rst(rst), .push(ctx_push), .pop(ctx_pop),
      .host_in(wreg_in[g*DATA_W +: DATA_W]),
      .restore_out(wreg_out[g*DATA_W +: DATA_W]));
  end

  // Context group: status word, only the arithmetic flags are shadowed.
  shadow_slot #(.W(STAT_W), .SAVE_MASK(STAT_SAVE_MASK)) u_stat (
    .clk(clk), .rst(rst), .push(ctx_push), .pop(ctx_pop),
    .host_in(stat_in), .restore_out(stat_out));

  restore_strobe u_ctx_vld (
    .clk(clk), .rst(rst), .pop(ctx_pop), .vld(ctx_restore_vld));

  // Loop group: own slots, tied to loop start and loop end.
  shadow_slot #(.W(LOOP_ADDR_W), .SAVE_MASK('1)) u_lstart (
    .clk(clk), .rst(rst), .push(loop_push), .pop(loop_pop),
    .host_in(lstart_in), .restore_out(lstart_out));
  shadow_slot #(.W(LOOP_ADDR_W), .SAVE_MASK('1)) u_lend (
    .clk(clk), .rst(rst), .push(loop_push), .pop(loop_pop),
    .host_in(lend_in), .restore_out(lend_out));
  shadow_slot #(.W(LOOP_CNT_W), .SAVE_MASK('1)) u_lcount (
    .clk(clk), .rst(rst), .push(loop_push), .pop(loop_pop),
    .host_in(lcount_in), .restore_out(lcount_out));

  restore_strobe u_loop_vld (
    .clk(clk), .rst(rst), .pop(loop_pop), .vld(loop_restore_vld));

  AST_CTX_VLD_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    ctx_pop |=> ctx_restore_vld); // R2
  AST_CTX_VLD_ONLY_POP: assert property (@(posedge clk) disable iff (rst)
    !ctx_pop |=> !ctx_restore_vld); // R2
  AST_LOOP_VLD_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    loop_pop |=> loop_restore_vld); // R4
  AST_LOOP_VLD_ONLY_POP: assert property (@(posedge clk) disable iff (rst)
    !loop_pop |=> !loop_restore_vld); // R4
  AST_WREG_IGNORES_LOOP: assert property (@(posedge clk) disable iff (rst)
    (loop_pop && !ctx_pop) |=> $stable(wreg_out)); // R6
  AST_LOOP_IGNORES_CTX: assert property (@(posedge clk) disable iff (rst)
    (ctx_pop && !loop_pop) |=> $stable(lcount_out)); // R6

  logic unused_w;
  assign unused_w = ^WBUS_W;
endmodule

// File: tb/ctx_shadow_store_tb.sv
`timescale 1ns/1ps
module ctx_shadow_store_tb_top;
  localparam logic [15:0] MASK = 16'h010F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctx_push = 0, ctx_pop = 0, loop_push = 0, loop_pop = 0;
  logic [63:0] wreg_in = '0;
  logic [15:0] stat_in = '0;
  logic [23:0] lstart_in = '0, lend_in = '0;
  logic [13:0] lcount_in = '0;
  logic [63:0] wreg_out;
  logic [15:0] stat_out;
  logic        ctx_restore_vld, loop_restore_vld;
  logic [23:0] lstart_out, lend_out;
  logic [13:0] lcount_out;

  always #5 clk = ~clk;

  ctx_shadow_store dut_i (
    .clk(clk), .rst(rst), .ctx_push(ctx_push), .ctx_pop(ctx_pop),
    .wreg_in(wreg_in), .stat_in(stat_in), .loop_push(loop_push),
    .loop_pop(loop_pop), .lstart_in(lstart_in), .lend_in(lend_in),
    .lcount_in(lcount_in), .wreg_out(wreg_out), .stat_out(stat_out),
    .ctx_restore_vld(ctx_restore_vld), .lstart_out(lstart_out),
    .lend_out(lend_out), .lcount_out(lcount_out),
    .loop_restore_vld(loop_restore_vld));

  int total = 0;
  int fails = 0;

  // Bench model of shadows and restore outputs.
  logic [63:0] m_wsh = '0, m_wout = '0;
  logic [15:0] m_ssh = '0, m_sout = '0;
  logic [23:0] m_lssh = '0, m_lsout = '0, m_lesh = '0, m_leout = '0;
  logic [13:0] m_lcsh = '0, m_lcout = '0;
  logic        m_cvld = 0, m_lvld = 0;
  logic [31:0] rs = 32'h1234_5678;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic rnd32(output logic [31:0] v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    v = rs;
  endtask

  task automatic new_data();
    logic [31:0] a, b, c;
    rnd32(a); rnd32(b); rnd32(c);
    wreg_in   = {a, b};
    stat_in   = c[15:0];
    lstart_in = a[23:0] ^ c;
    lend_in   = b[23:0] ^ {c[15:0], 8'h5A};
    lcount_in = c[29:16];
  endtask

  task automatic compare(input string tag);
    check(wreg_out == m_wout, tag, "wreg_out", wreg_out, m_wout);
    check(stat_out == m_sout, tag, "stat_out", 64'(stat_out), 64'(m_sout));
    check(ctx_restore_vld == m_cvld, tag, "ctx_restore_vld",
          64'(ctx_restore_vld), 64'(m_cvld));
    check(lstart_out == m_lsout, tag, "lstart_out", 64'(lstart_out), 64'(m_lsout));
    check(lend_out == m_leout, tag, "lend_out", 64'(lend_out), 64'(m_leout));
    check(lcount_out == m_lcout, tag, "lcount_out", 64'(lcount_out), 64'(m_lcout));
    check(loop_restore_vld == m_lvld, tag, "loop_restore_vld",
          64'(loop_restore_vld), 64'(m_lvld));
  endtask

  // One clock: strobes driven on the falling edge, results sampled after rise.
  task automatic step(input bit cpu, input bit cpo, input bit lpu,
                      input bit lpo, input string tag);
    @(negedge clk);
    ctx_push = cpu; ctx_pop = cpo; loop_push = lpu; loop_pop = lpo;
    m_cvld = cpo;
    m_lvld = lpo;
    if (cpo) begin
      m_wout = m_wsh;
      m_sout = m_ssh | (stat_in & ~MASK);
    end
    if (cpu) begin
      m_wsh = wreg_in;
      m_ssh = stat_in & MASK;
    end
    if (lpo) begin
      m_lsout = m_lssh; m_leout = m_lesh; m_lcout = m_lcsh;
    end
    if (lpu) begin
      m_lssh = lstart_in; m_lesh = lend_in; m_lcsh = lcount_in;
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    new_data();
    repeat (3) @(posedge clk);
    #1;
    compare("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    compare("R1 after reset");

    // R7: pop with nothing pushed; unsaved status bits pass through.
    stat_in = 16'hFFFF;
    step(0, 1, 0, 1, "R7 empty pop");
    step(0, 0, 0, 0, "R2 valid drops");

    // R2/R3/R10: push, disturb host inputs, pop.
    new_data();
    step(1, 0, 0, 0, "R2 push");
    new_data();
    step(0, 0, 0, 0, "R10 host change");
    new_data();
    step(0, 1, 0, 0, "R3 pop flags");
    step(0, 0, 0, 0, "R9 hold");

    // R5: second push overwrites.
    new_data();
    step(1, 0, 0, 0, "R5 push A");
    new_data();
    step(1, 0, 0, 0, "R5 push B");
    step(0, 1, 0, 0, "R5 pop B");

    // R8: push and pop on one edge.
    new_data();
    step(1, 1, 1, 1, "R8 same edge");
    new_data();
    step(0, 1, 0, 1, "R8 newer kept");

    // R4: loop start/end.
    new_data();
    step(0, 0, 1, 0, "R4 loop start");
    new_data();
    step(0, 0, 0, 0, "R10 loop host change");
    step(0, 0, 0, 1, "R4 loop end");

    // R6/R9: sweep every strobe combination with fresh data.
    for (int i = 0; i < 512; i++) begin
      logic [3:0] s;
      s = 4'(i) ^ 4'(i >> 4);
      new_data();
      step(s[0], s[1], s[2], s[3], "R6 sweep");
    end
    step(0, 0, 0, 0, "R9 final hold");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule